// File: doc/BRIEF.md
# Self-Correcting Synchronous Decade Counter

This block is a four-bit synchronous counter that runs through the codes 0 to 9 and then returns to 0. It is built from four toggle flip-flops that share one clock. Bit 0 is the least significant stage. On each edge a small set of minimised toggle equations decides which stages invert. All stages update on the same edge, so no change ripples from one stage to the next.

The six codes above 9 are never reached in normal counting. The toggle equations assign them on purpose, so that each unused code has a fixed path back into the decimal loop within two enabled clocks. A counter that wakes up in one of those codes recovers without outside help. A synchronous preset port loads any code, which lets the recovery paths be exercised directly. A terminal-count flag marks the last decade step while counting is enabled.

Top module: `decade_tcounter`

## Requirements
- R1: When `rst` is 1 at a rising edge, `count` becomes 0000 on that edge. This holds whatever values `load_en` and `cnt_en` have.
- R2: When `rst` is 0 and `load_en` is 1 at a rising edge, `count` takes `load_val` on that edge, for any value of `cnt_en`.
- R3: When `cnt_en` is 1 and the preset is idle, a state from 0 to 8 advances by exactly one on each rising edge.
- R4: When `cnt_en` is 1 and the preset is idle, state 9 (1001) steps to 0 (0000).
- R5: When `cnt_en` is 0 and the preset is idle, every toggle input is 0 and `count` holds its value.
- R6: With counting enabled, each even unused code steps to the code one above it: 10 to 11, 12 to 13, 14 to 15.
- R7: With counting enabled, each odd unused code falls back into the decimal loop: 11 to 6, 13 to 4, 15 to 2.
- R8: `term_cnt` is 1 exactly when `count` is 9 and `cnt_en` is 1, in the same cycle and with no register in between. It is 0 for every other combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all four stages |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| cnt_en | input | 1 | Count enable; gates all four toggle inputs |
| load_en | input | 1 | Synchronous preset strobe, active high |
| load_val | input | 4 | Code written by the preset |
| count | output | 4 | Current counter state, bit 0 least significant |
| term_cnt | output | 1 | High when the state is 9 and counting is enabled |

## Verification
The state register is the only register on any path in this block. A reset, a preset or an enabled step therefore shows on `count` one rising edge after the inputs are applied. `term_cnt` is combinational and is valid in the same cycle as the state and enable it depends on. The bench drives inputs on the falling edge. It reads `count` on the falling edge that follows the active rising edge, and it reads `term_cnt` on the falling edge just before that rising edge, while the starting state is still present. Each vector presets a starting code, applies one step and compares the result with the expected next code. A run of 25 enabled steps is then compared with a modulo-10 model kept in the bench.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int CNT_W    = 4;
    localparam int LAST_DIG = 9;

    typedef logic [CNT_W-1:0] dec_code_t;

    typedef struct packed {
        dec_code_t state;
    } bank_regs_t;
endpackage

// File: rtl/dec_toggle_eq.sv
module dec_toggle_eq
    import dec_pkg::*;
(
    input  dec_code_t cur,
    input  logic      en,
    output dec_code_t tgl
);
    logic a_b, a_c, a_d, b_b;

    assign a_b = cur[0];
    assign b_b = cur[1];
    assign a_c = cur[2];
    assign a_d = cur[3];

    always_comb begin
        tgl    = '0;
        tgl[0] = en;
        tgl[1] = en & a_b & ~a_d;
        tgl[2] = en & a_b & b_b;
        tgl[3] = en & ((a_b & b_b & a_c) | (a_b & a_d));
    end
endmodule

// File: rtl/dec_tff_bank.sv
module dec_tff_bank
    import dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_en,
    input  dec_code_t load_val,
    input  dec_code_t tgl,
    output dec_code_t q
);
    bank_regs_t regs_d, regs_q;
    dec_code_t  flipped;

    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        assign flipped[i] = regs_q.state[i] ^ tgl[i];
    end

    always_comb begin
        regs_d = regs_q;
        if (rst)
            regs_d.state = '0;
        else if (load_en)
            regs_d.state = load_val;
        else
            regs_d.state = flipped;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign q = regs_q.state;

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && tgl == '0) |=> $stable(regs_q.state));

    // R2
    preset_takes_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (regs_q.state == $past(load_val)));
endmodule

// File: rtl/decade_tcounter.sv
module decade_tcounter
    import dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       load_en,
    input  logic [3:0] load_val,
    output logic [3:0] count,
    output logic       term_cnt
);
    dec_code_t state_q;
    dec_code_t toggles;

    dec_toggle_eq i_eq (
        .cur (state_q),
        .en  (cnt_en),
        .tgl (toggles)
    );

    dec_tff_bank i_bank (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .tgl      (toggles),
        .q        (state_q)
    );

    assign count    = state_q;
    assign term_cnt = cnt_en && (state_q == dec_code_t'(LAST_DIG));

    logic step_ok;
    assign step_ok = cnt_en && !load_en && !rst;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (count == 4'd0));

    // R3
    inc_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (step_ok && count < 4'd9) |=> (count == 4'($past(count) + 4'd1)));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (step_ok && count == 4'd9) |=> (count == 4'd0));

    // R6
    even_spare_chk: assert property (@(posedge clk) disable iff (rst)
        (step_ok && count > 4'd9 && !count[0]) |=> (count == 4'($past(count) + 4'd1)));

    // R7
    odd_spare_chk: assert property (@(posedge clk) disable iff (rst)
        (step_ok && count > 4'd9 && count[0]) |=> (count < 4'd9 && !count[0]));
endmodule

// File: tb/test_decade_tcounter.sv
module test_decade_tcounter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic [3:0] count;
    logic       term_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    decade_tcounter i_decade_tcounter (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .load_en  (load_en),
        .load_val (load_val),
        .count    (count),
        .term_cnt (term_cnt)
    );

    // {start[3:0], enable, expected next[3:0], expected term_cnt}
    localparam int NV = 19;
    localparam logic [9:0] VEC [0:NV-1] = '{
        {4'd0,  1'b1, 4'd1,  1'b0},
        {4'd1,  1'b1, 4'd2,  1'b0},
        {4'd2,  1'b1, 4'd3,  1'b0},
        {4'd3,  1'b1, 4'd4,  1'b0},
        {4'd4,  1'b1, 4'd5,  1'b0},
        {4'd5,  1'b1, 4'd6,  1'b0},
        {4'd6,  1'b1, 4'd7,  1'b0},
        {4'd7,  1'b1, 4'd8,  1'b0},
        {4'd8,  1'b1, 4'd9,  1'b0},
        {4'd9,  1'b1, 4'd0,  1'b1},
        {4'd10, 1'b1, 4'd11, 1'b0},
        {4'd11, 1'b1, 4'd6,  1'b0},
        {4'd12, 1'b1, 4'd13, 1'b0},
        {4'd13, 1'b1, 4'd4,  1'b0},
        {4'd14, 1'b1, 4'd15, 1'b0},
        {4'd15, 1'b1, 4'd2,  1'b0},
        {4'd5,  1'b0, 4'd5,  1'b0},
        {4'd9,  1'b0, 4'd9,  1'b0},
        {4'd12, 1'b0, 4'd12, 1'b0}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] s, input logic e);
        if (!e)        return "R5";
        if (s < 4'd9)  return "R3";
        if (s == 4'd9) return "R4";
        if (!s[0])     return "R6";
        return "R7";
    endfunction

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [3:0] model;
        repeat (2) @(negedge clk);
        // R1: reset state
        rst = 1'b0;
        check("R1", count, 4'd0);
        check("R8", {3'b0, term_cnt}, 4'd0);

        for (int v = 0; v < NV; v++) begin
            logic [3:0] s, nx;
            logic e, t;
            {s, e, nx, t} = VEC[v];
            load_en = 1'b1; load_val = s; cnt_en = e;
            @(negedge clk);
            load_en = 1'b0;
            check("R2", count, s);
            check("R8", {3'b0, term_cnt}, {3'b0, t});
            @(negedge clk);
            check(tag_of(s, e), count, nx);
        end

        // R1: reset wins over preset and enable
        load_en = 1'b1; load_val = 4'd7; cnt_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R1", count, 4'd0);

        // R2: preset with counting disabled
        rst = 1'b0; cnt_en = 1'b0; load_val = 4'd14;
        @(negedge clk);
        load_en = 1'b0;
        check("R2", count, 4'd14);

        // R3 R4: long enabled run from reset against a modulo-10 model
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; cnt_en = 1'b1; model = 4'd0;
        for (int k = 0; k < 25; k++) begin
            check("R8", {3'b0, term_cnt}, {3'b0, model == 4'd9});
            @(negedge clk);
            model = (model == 4'd9) ? 4'd0 : model + 4'd1;
            check(model == 4'd0 ? "R4" : "R3", count, model);
        end
        cnt_en = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule